// File: doc/BRIEF.md
# Handshaked Response Frame Transmitter

This block sends one response frame at a time to a host over a byte-wide link. Every byte uses a four-phase SYN/ACK handshake. A command parser fills a frame buffer and gives the frame length. It then pulses a start strobe for one cycle. On that strobe the transmitter takes a private copy of the buffer and the length. From then on the parser may reuse its buffer at once.

The frame starts with the start-of-response marker 0xAA and ends with the end-of-response marker 0x55. The length from the parser marks where the frame ends. Because of this, a 0x55 that appears inside an address or data field does not end the frame early. For each byte the block puts the data on the bus and raises SYN. It holds both until the host raises ACK. It then drops SYN and waits for the host to release ACK before it moves to the next byte. After the handshake of the last byte finishes, the block pulses a done flag for one cycle and becomes idle again.

Top module: `resp_frame_tx`

## Requirements
- R1: After reset, `hostSyn`, `busy` and `donePulse` are all 0.
- R2: A `startReq` that is sampled while idle captures `frameBuf` and `frameLen`. `busy` is 1 from the next cycle onwards. The first byte sent is buffer byte 0, which is bits [7:0] of `frameBuf`. Byte i is bits [8i+7:8i].
- R3: While `hostSyn` is 1 and `hostAck` has not yet been seen, `hostData` holds its value.
- R4: `hostSyn` rises only after `hostAck` has been sampled low. This also applies to the first byte when ACK is already high at start. `hostSyn` stays high until `hostAck` is sampled high, and is low in the next cycle.
- R5: After a byte's handshake, SYN for the next byte does not rise while `hostAck` is still high.
- R6: Buffer bytes 0 to L-1 are sent in order, where L is the effective length. Bytes of value 0x55 before position L-1 do not end the frame.
- R7: After ACK of the final byte is sampled low, `donePulse` is 1 for exactly one cycle. In that same cycle `busy` is 0.
- R8: While busy, a `startReq` and any change to `frameBuf` or `frameLen` have no effect. The current frame is unchanged, and no second frame follows it.
- R9: The effective length L is `frameLen` clamped to the range MIN_BYTES..MAX_BYTES, which is 3..9 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to send the loaded frame |
| frameLen | input | LEN_W (4) | Frame length in bytes, including both markers |
| frameBuf | input | MAX_BYTES*8 (72) | Frame bytes, byte 0 in the low bits |
| hostAck | input | 1 | Acknowledge from the host |
| hostSyn | output | 1 | Byte-valid strobe to the host |
| hostData | output | 8 | Current byte |
| busy | output | 1 | Frame in progress |
| donePulse | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with its default parameters: MAX_BYTES of 9 and MIN_BYTES of 3. These cover every response length from the shortest to the longest. They also make both clamp edges reachable with a 4-bit length field, using values 1 and 15. The longest frame carries 0x55 inside its address and data fields. This shows that the frame ends by position and not by the marker value. Different host ACK delays check how long SYN is held and how long data stays stable.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_WAITACK = 2'd2,
    ST_RELEASE = 2'd3
  } txState_t;

  typedef struct packed {
    logic load;
    logic advance;
  } txStrobes_t;
endpackage

// File: rtl/resp_tx_datapath.sv
module resp_tx_datapath #(
  parameter int MAX_BYTES = 9,
  parameter int MIN_BYTES = 3,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1),
  parameter int IDX_W     = $clog2(MAX_BYTES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  resp_tx_pkg::txStrobes_t  strobes,
  input  logic [LEN_W-1:0]         frameLen,
  input  logic [MAX_BYTES*8-1:0]   frameBuf,
  output logic [7:0]               hostData,
  output logic                     isLast
);
  localparam logic [LEN_W-1:0] MinLen = LEN_W'(MIN_BYTES);
  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(MAX_BYTES);

  logic [MAX_BYTES*8-1:0] bufReg;
  logic [IDX_W-1:0]       idx;
  logic [IDX_W-1:0]       lastIdx;
  logic [LEN_W-1:0]       clampLen;
  logic [7:0]             bufBytes [MAX_BYTES];

  always_comb begin
    if (frameLen < MinLen)      clampLen = MinLen;
    else if (frameLen > MaxLen) clampLen = MaxLen;
    else                        clampLen = frameLen;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gUnpack
    assign bufBytes[g] = bufReg[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg  <= '0;
      idx     <= '0;
      lastIdx <= '0;
    end else if (strobes.load) begin
      bufReg  <= frameBuf;
      idx     <= '0;
      lastIdx <= IDX_W'(clampLen - LEN_W'(1));
    end else if (strobes.advance) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign hostData = bufBytes[idx];
  assign isLast   = (idx == lastIdx);
endmodule

// File: rtl/resp_tx_control.sv
module resp_tx_control (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic                     hostAck,
  input  logic                     isLast,
  output resp_tx_pkg::txStrobes_t  strobes,
  output logic                     hostSyn,
  output logic                     busy,
  output logic                     donePulse
);
  import resp_tx_pkg::*;

  txState_t state, nextState;
  logic     doneNext;

  always_comb begin
    nextState       = state;
    strobes.load    = 1'b0;
    strobes.advance = 1'b0;
    doneNext        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.load = 1'b1;
          nextState    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (!hostAck) nextState = ST_WAITACK;
      end
      ST_WAITACK: begin
        if (hostAck) nextState = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (!hostAck) begin
          if (isLast) begin
            nextState = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            strobes.advance = 1'b1;
            nextState       = ST_SETUP;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= doneNext;
    end
  end

  assign hostSyn = (state == ST_WAITACK);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/resp_frame_tx.sv
module resp_frame_tx #(
  parameter int MAX_BYTES = 9,
  parameter int MIN_BYTES = 3,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [LEN_W-1:0]       frameLen,
  input  logic [MAX_BYTES*8-1:0] frameBuf,
  input  logic                   hostAck,
  output logic                   hostSyn,
  output logic [7:0]             hostData,
  output logic                   busy,
  output logic                   donePulse
);
  resp_tx_pkg::txStrobes_t strobes;
  logic isLast;

  resp_tx_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .hostAck   (hostAck),
    .isLast    (isLast),
    .strobes   (strobes),
    .hostSyn   (hostSyn),
    .busy      (busy),
    .donePulse (donePulse)
  );

  resp_tx_datapath #(
    .MAX_BYTES (MAX_BYTES),
    .MIN_BYTES (MIN_BYTES),
    .LEN_W     (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .frameLen (frameLen),
    .frameBuf (frameBuf),
    .hostData (hostData),
    .isLast   (isLast)
  );
endmodule

// File: rtl/resp_frame_tx_chk.sv
module resp_frame_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostAck,
  input logic       hostSyn,
  input logic [7:0] hostData,
  input logic       busy,
  input logic       donePulse
);
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostSyn && !hostAck) |=> $stable(hostData));

  p_syn_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostSyn && !hostAck) |=> hostSyn);

  p_syn_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostSyn && hostAck) |=> !hostSyn);

  p_syn_after_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostSyn) |-> $past(!hostAck));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !hostSyn);
endmodule

bind resp_frame_tx resp_frame_tx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostAck   (hostAck),
  .hostSyn   (hostSyn),
  .hostData  (hostData),
  .busy      (busy),
  .donePulse (donePulse)
);

// File: tb/tb_resp_frame_tx.sv
module tb_resp_frame_tx;
  localparam int MAX_BYTES = 9;
  localparam int MIN_BYTES = 3;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int NVEC      = 4;

  localparam logic [71:0] VBUF [NVEC] = '{
    72'h55_56_34_12_55_55_00_7F_AA,
    72'h00_00_00_00_55_34_12_7E_AA,
    72'h00_00_00_00_00_00_55_7D_AA,
    72'h00_00_00_00_00_55_11_FD_AA
  };
  localparam logic [3:0] VLEN [NVEC] = '{4'd9, 4'd5, 4'd3, 4'd4};
  localparam int         VDLY [NVEC] = '{0, 2, 5, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic [MAX_BYTES*8-1:0] frameBuf = '0;
  logic hostAck = 1'b0;
  logic hostSyn, busy, donePulse;
  logic [7:0] hostData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  resp_frame_tx dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .frameLen(frameLen),
    .frameBuf(frameBuf), .hostAck(hostAck), .hostSyn(hostSyn),
    .hostData(hostData), .busy(busy), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int effLen(input int len);
    if (len < MIN_BYTES) return MIN_BYTES;
    if (len > MAX_BYTES) return MAX_BYTES;
    return len;
  endfunction

  // Sends one frame as the host; optional mid-frame start with another buffer.
  task automatic runFrame(input logic [71:0] buf_, input int len, input int dly,
                          input bit injectMid);
    int expN = effLen(len);
    int got = 0;
    bit done = 0;
    int guard = 0;
    logic [7:0] d;
    @(negedge clk);
    frameBuf = buf_; frameLen = LEN_W'(len); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R2 busy", 72'(busy), 72'd1);
    while (!done && guard < 2000) begin
      guard++;
      @(negedge clk);
      if (donePulse) begin
        done = 1;
        check(busy == 1'b0, "R7 busy low at done", 72'(busy), 72'd0);
      end else if (hostSyn && !hostAck) begin
        d = hostData;
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          check(hostSyn && hostData == d, "R3 data/syn held", 72'(hostData), 72'(d));
        end
        check(got < expN && d == buf_[got*8 +: 8], "R6 byte value", 72'(d),
              72'(buf_[got*8 +: 8]));
        got++;
        if (injectMid && got == 2) begin
          frameBuf = ~buf_; frameLen = 4'd3; startReq = 1'b1;
        end
        hostAck = 1'b1;
        @(negedge clk);
        startReq = 1'b0;
        check(!hostSyn, "R4 syn drops after ack", 72'(hostSyn), 72'd0);
        @(negedge clk);
        check(!hostSyn, "R5 no syn while ack high", 72'(hostSyn), 72'd0);
        hostAck = 1'b0;
      end
    end
    check(done, "R7 done seen", 72'(done), 72'd1);
    check(got == expN, "R6 R9 byte count", 72'(got), 72'(expN));
    @(negedge clk);
    check(!donePulse, "R7 done one cycle", 72'(donePulse), 72'd0);
    if (injectMid) begin
      repeat (4) @(negedge clk);
      check(!busy && !hostSyn, "R8 no second frame", 72'(busy), 72'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!hostSyn && !busy && !donePulse, "R1 reset outputs",
          72'({hostSyn, busy, donePulse}), 72'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R1 idle after reset", 72'(busy), 72'd0);

    for (int v = 0; v < NVEC; v++) runFrame(VBUF[v], int'(VLEN[v]), VDLY[v], 1'b0);

    // R9 clamp low and high
    runFrame(VBUF[0], 1, 0, 1'b0);
    runFrame(VBUF[0], 15, 1, 1'b0);

    // R8 start during frame ignored, buffer change ignored
    runFrame(VBUF[0], 9, 1, 1'b1);

    // R4 ack already high at start: SYN must wait
    hostAck = 1'b1;
    @(negedge clk);
    frameBuf = VBUF[2]; frameLen = 4'd3; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!hostSyn, "R4 syn waits for ack low", 72'(hostSyn), 72'd0);
    end
    hostAck = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(hostSyn && hostData == 8'hAA, "R2 R4 first byte after release",
          72'(hostData), 72'hAA);
    repeat (2) begin
      hostAck = 1'b1; @(negedge clk); @(negedge clk);
      hostAck = 1'b0; @(negedge clk); @(negedge clk);
    end
    hostAck = 1'b1; @(negedge clk); @(negedge clk);
    hostAck = 1'b0; @(negedge clk);
    check(donePulse, "R7 done after last release", 72'(donePulse), 72'd1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule